// File: doc/BRIEF.md
# Converter Output Code Formatter

This block is the last digital stage of a pipelined sampling converter. Each sample clock it takes a corrected offset-binary word and a raw out-of-range flag. It carries both through a fixed pipeline and produces a registered output word. The word is either straight offset binary or two's complement, chosen by one control input. The two's-complement form is made by inverting only the most significant bit.

When the flag marks a sample as out of range, the word is clamped to the code for the matching rail. The direction comes from the sample's MSB: MSB high clamps to positive full scale, MSB low to negative full scale. The flag travels in the same pipeline as the word, so the flag and its word reach the output on the same edge.

Either of two power-down inputs discards everything in flight. A small state machine then governs the refill. Its states are HALT (power-down asserted, or reset), FILL (counting edges while the pipeline refills) and STREAM (a word loads on every edge). Its transitions are:
- any state to HALT whenever a power-down input is sampled high;
- HALT to FILL on the first edge with both power-downs low;
- FILL to STREAM on the edge that loads the first refilled word.

The output pins' high-impedance condition is modelled by a drive-enable output, taken from an active-low enable input.

Top module: `adcfmt_top`

## Requirements
- R1: While rst_n is low, data_out is 0x000, ovr_out is 0 and valid_out is 0.
- R2: With fmt_twos low, a word in range is output unchanged (straight offset binary); mid-scale input 0x800 gives 0x800.
- R3: With fmt_twos high, only bit 11 of the word is inverted (two's complement); mid-scale input 0x800 gives 0x000.
- R4: A word with ovr_in high is clamped: sample bit 11 high gives 0xFFF (0x7FF in two's complement), bit 11 low gives 0x000 (0x800 in two's complement).
- R5: ovr_out reflects ovr_in of the same word, changes on the same edge as data_out, and stays high for as long as consecutive words are out of range.
- R6: In steady operation, a word captured at edge n appears on data_out after edge n+LAT-1 (LAT=5 by default), so the capture edge and the output edge together make LAT edges.
- R7: fmt_twos is applied when a word is loaded into the output register; changing it does not recode the word already held.
- R8: An edge with std_pd or quasi_pd high clears valid_out after that edge, holds data_out and ovr_out, and discards every word in flight.
- R9: After power-down or reset is released, valid_out stays low, and data_out holds, until the word captured on the first edge with power-down low is loaded LAT-1 edges later; valid_out rises with that word.
- R10: out_drive equals the inverse of oe_n at all times; oe_n does not change data_out, ovr_out or valid_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_in | input | 12 | Corrected offset-binary sample |
| ovr_in | input | 1 | Raw out-of-range flag for smp_in |
| fmt_twos | input | 1 | Output code select: 0 offset binary, 1 two's complement |
| oe_n | input | 1 | Active-low output enable |
| std_pd | input | 1 | Standard power-down request, active high |
| quasi_pd | input | 1 | Quasi power-down request, active high |
| data_out | output | 12 | Registered formatted output word |
| ovr_out | output | 1 | Registered over-range flag aligned to data_out |
| valid_out | output | 1 | High when data_out holds a word from the current run |
| out_drive | output | 1 | Drive enable for data_out and ovr_out pins |

## Verification
The assertions take the power-down inputs as synchronous to clk and stable around each rising edge. They also take an out-of-range word as one whose lower eleven bits are forced to equal the sign side of the rail. The bench drives every input on the falling edge, so each input is settled well before the sampling edge. The random phase holds power-down pulses short and rare, so most of the run is spent in STREAM, while FILL is still entered and left many times, including by pulses that land in the middle of a refill.

// File: rtl/adcfmt_pkg.sv
package adcfmt_pkg;

    typedef enum logic [1:0] {
        ST_HALT   = 2'd0,
        ST_FILL   = 2'd1,
        ST_STREAM = 2'd2
    } fmt_state_e;

endpackage

// File: rtl/adcfmt_stages.sv
module adcfmt_stages #(
    parameter int W     = 13,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_st
            logic [W-1:0] q;
            if (i == 0) begin : g_head
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)        q <= '0;
                    else if (shift_en) q <= d_in;
                end
            end else begin : g_body
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)        q <= '0;
                    else if (shift_en) q <= g_st[i-1].q;
                end
            end
        end
    endgenerate

    assign d_out = g_st[DEPTH-1].q;

endmodule

// File: rtl/adcfmt_coder.sv
module adcfmt_coder #(
    parameter int W = 12
) (
    input  logic [W-1:0] raw,
    input  logic         ovr,
    input  logic         twos,
    output logic [W-1:0] code
);

    logic [W-1:0] clamped;

    always_comb begin
        // an out-of-range word goes to the rail its MSB points at
        clamped = ovr ? {W{raw[W-1]}} : raw;
        code    = {clamped[W-1] ^ twos, clamped[W-2:0]};
    end

endmodule

// File: rtl/adcfmt_ctrl.sv
module adcfmt_ctrl
    import adcfmt_pkg::*;
#(
    parameter int LAT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd,
    output logic shift_en,
    output logic load_out
);

    localparam int CW = (LAT > 2) ? $clog2(LAT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LAT - 1);

    fmt_state_e state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HALT;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // next state and fill counter
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        if (pd) begin
            state_nx = ST_HALT;
            cnt_nx   = '0;
        end else begin
            unique case (state)
                ST_HALT: begin
                    state_nx = ST_FILL;
                    cnt_nx   = CW'(1);
                end
                ST_FILL: begin
                    if (cnt == LAST) begin
                        state_nx = ST_STREAM;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt + CW'(1);
                    end
                end
                ST_STREAM: begin
                    state_nx = ST_STREAM;
                end
                default: begin
                    state_nx = ST_HALT;
                    cnt_nx   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        shift_en = !pd;
        load_out = 1'b0;
        if (!pd) begin
            unique case (state)
                ST_HALT:   load_out = (LAT == 1);
                ST_FILL:   load_out = (cnt == LAST);
                ST_STREAM: load_out = 1'b1;
                default:   load_out = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/adcfmt_top.sv
module adcfmt_top #(
    parameter int W   = 12,
    parameter int LAT = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] smp_in,
    input  logic         ovr_in,
    input  logic         fmt_twos,
    input  logic         oe_n,
    input  logic         std_pd,
    input  logic         quasi_pd,
    output logic [W-1:0] data_out,
    output logic         ovr_out,
    output logic         valid_out,
    output logic         out_drive
);

    localparam int DEPTH = LAT - 1;
    localparam int SW    = W + 1;

    logic          pd_any;
    logic          shift_en;
    logic          load_out;
    logic [SW-1:0] tail;
    logic [W-1:0]  code;

    assign pd_any    = std_pd | quasi_pd;
    assign out_drive = !oe_n;

    adcfmt_ctrl #(.LAT(LAT)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .pd       (pd_any),
        .shift_en (shift_en),
        .load_out (load_out)
    );

    adcfmt_stages #(.W(SW), .DEPTH(DEPTH)) u_stages (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .d_in     ({ovr_in, smp_in}),
        .d_out    (tail)
    );

    adcfmt_coder #(.W(W)) u_coder (
        .raw  (tail[W-1:0]),
        .ovr  (tail[W]),
        .twos (fmt_twos),
        .code (code)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_out  <= '0;
            ovr_out   <= 1'b0;
            valid_out <= 1'b0;
        end else begin
            valid_out <= load_out;
            if (load_out) begin
                data_out <= code;
                ovr_out  <= tail[W];
            end
        end
    end

endmodule

// File: rtl/adcfmt_chk.sv
module adcfmt_chk #(
    parameter int W   = 12,
    parameter int LAT = 5
) (
    input logic         clk,
    input logic         rst_n,
    input logic         std_pd,
    input logic         quasi_pd,
    input logic [W-1:0] data_out,
    input logic         ovr_out,
    input logic         valid_out
);

    localparam int RW = $clog2(LAT + 1);

    logic          pd_any;
    logic [RW-1:0] run_cnt;

    assign pd_any = std_pd | quasi_pd;

    // edges with power-down low since the last power-down or reset, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 run_cnt <= '0;
        else if (pd_any)            run_cnt <= '0;
        else if (run_cnt != RW'(LAT)) run_cnt <= run_cnt + RW'(1);
    end

    // R8: power-down clears valid on the next cycle
    p_pd_clears_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pd_any |=> !valid_out);

    // R8: power-down holds the output word and flag
    p_pd_holds_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pd_any |=> ($stable(data_out) && $stable(ovr_out)));

    // R4, R5: a flagged word is a rail code
    p_ovr_rail_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && ovr_out) |-> (data_out[W-2:0] == {(W-1){data_out[W-2]}}));

    // R9: valid only rises after a full refill
    p_refill_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_out) |-> (run_cnt >= RW'(LAT)));

    // R6: a running stream stays valid while power-down is low
    p_stream_continues_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && !pd_any) |=> valid_out);

endmodule

bind adcfmt_top adcfmt_chk #(.W(W), .LAT(LAT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .std_pd    (std_pd),
    .quasi_pd  (quasi_pd),
    .data_out  (data_out),
    .ovr_out   (ovr_out),
    .valid_out (valid_out)
);

// File: tb/sim_adcfmt_top.sv
module sim_adcfmt_top;

    localparam int W   = 12;
    localparam int LAT = 5;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] smp_in;
    logic         ovr_in, fmt_twos, oe_n, std_pd, quasi_pd;
    logic [W-1:0] data_out;
    logic         ovr_out, valid_out, out_drive;

    int    checks   = 0;
    int    failures = 0;
    string tag      = "R1";

    always #5 clk = ~clk;

    adcfmt_top #(.W(W), .LAT(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .ovr_in(ovr_in),
        .fmt_twos(fmt_twos), .oe_n(oe_n), .std_pd(std_pd), .quasi_pd(quasi_pd),
        .data_out(data_out), .ovr_out(ovr_out), .valid_out(valid_out),
        .out_drive(out_drive)
    );

    // behavioural reference: a queue of captured words since the last halt
    logic [W:0]   mq[$];
    logic [W:0]   mw;
    logic [W-1:0] m_data = '0;
    logic         m_ovr  = 1'b0;
    logic         m_vld  = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_data = '0; m_ovr = 1'b0; m_vld = 1'b0;
        end else if (std_pd || quasi_pd) begin
            mq.delete();
            m_vld = 1'b0;
        end else begin
            mq.push_back({ovr_in, smp_in});
            if (mq.size() == LAT) begin
                int v;
                mw = mq.pop_front();
                if (mw[W]) v = mw[W-1] ? (1 << W) - 1 : 0;
                else       v = int'(mw[W-1:0]);
                if (fmt_twos) v = (v + (1 << (W-1))) % (1 << W);
                m_data = W'(v);
                m_ovr  = mw[W];
                m_vld  = 1'b1;
            end else begin
                m_vld = 1'b0;
            end
        end
    end

    task automatic cmp_model();
        checks++;
        if (valid_out !== m_vld || data_out !== m_data || ovr_out !== m_ovr
            || out_drive !== !oe_n) begin
            failures++;
            $display("FAIL %s model: got v=%b d=%h o=%b e=%b exp v=%b d=%h o=%b e=%b",
                     tag, valid_out, data_out, ovr_out, out_drive,
                     m_vld, m_data, m_ovr, !oe_n);
        end
    endtask

    task automatic expect_eq(string t, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s: got %0h exp %0h", t, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cmp_model();
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL R6 watchdog: got running exp finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; smp_in = 12'h800; ovr_in = 1'b0; fmt_twos = 1'b0;
        oe_n = 1'b0; std_pd = 1'b0; quasi_pd = 1'b0;
        steps(3);
        tag = "R1";
        expect_eq("R1 data", int'(data_out), 0);
        expect_eq("R1 ovr", int'(ovr_out), 0);
        expect_eq("R1 valid", int'(valid_out), 0);

        // refill after reset
        rst_n = 1'b1;
        tag = "R9";
        steps(LAT - 1);
        expect_eq("R9 valid before refill", int'(valid_out), 0);
        expect_eq("R9 data held", int'(data_out), 0);
        step();
        expect_eq("R9 valid after refill", int'(valid_out), 1);
        tag = "R2";
        expect_eq("R2 midscale offset", int'(data_out), 12'h800);
        smp_in = 12'h3A5; steps(LAT);
        expect_eq("R2 passthrough", int'(data_out), 12'h3A5);

        // two's complement
        tag = "R3";
        fmt_twos = 1'b1; smp_in = 12'h800; steps(LAT);
        expect_eq("R3 midscale twos", int'(data_out), 12'h000);
        smp_in = 12'h3A5; steps(LAT);
        expect_eq("R3 msb invert", int'(data_out), 12'hBA5);

        // latency: A steady, then B
        tag = "R6";
        fmt_twos = 1'b0; smp_in = 12'h111; steps(LAT);
        smp_in = 12'h222;
        steps(LAT - 1);
        expect_eq("R6 old word still out", int'(data_out), 12'h111);
        step();
        expect_eq("R6 new word after LAT edges", int'(data_out), 12'h222);

        // clamps and flag
        tag = "R4";
        ovr_in = 1'b1; smp_in = 12'hF00; steps(LAT);
        expect_eq("R4 pos clamp offset", int'(data_out), 12'hFFF);
        tag = "R5";
        expect_eq("R5 ovr high", int'(ovr_out), 1);
        steps(3);
        expect_eq("R5 ovr stays high", int'(ovr_out), 1);
        tag = "R4";
        fmt_twos = 1'b1; steps(LAT);
        expect_eq("R4 pos clamp twos", int'(data_out), 12'h7FF);
        smp_in = 12'h0A0; steps(LAT);
        expect_eq("R4 neg clamp twos", int'(data_out), 12'h800);
        fmt_twos = 1'b0; steps(LAT);
        expect_eq("R4 neg clamp offset", int'(data_out), 12'h000);
        tag = "R5";
        ovr_in = 1'b0; smp_in = 12'h456; steps(LAT);
        expect_eq("R5 ovr low in range", int'(ovr_out), 0);

        // power-down hold and format change during hold
        tag = "R8";
        std_pd = 1'b1; step();
        expect_eq("R8 valid cleared", int'(valid_out), 0);
        expect_eq("R8 data held", int'(data_out), 12'h456);
        tag = "R7";
        fmt_twos = 1'b1; steps(3);
        expect_eq("R7 held word not recoded", int'(data_out), 12'h456);
        std_pd = 1'b0; smp_in = 12'h789;
        tag = "R9";
        steps(LAT - 1);
        expect_eq("R9 valid low while refilling", int'(valid_out), 0);
        step();
        tag = "R7";
        expect_eq("R7 new word recoded", int'(data_out), 12'hF89);

        tag = "R8";
        fmt_twos = 1'b0;
        quasi_pd = 1'b1; step();
        expect_eq("R8 quasi valid cleared", int'(valid_out), 0);
        quasi_pd = 1'b0; steps(2);
        quasi_pd = 1'b1; step();
        quasi_pd = 1'b0; steps(LAT + 2);

        // output enable
        tag = "R10";
        oe_n = 1'b1; #1;
        expect_eq("R10 drive off", int'(out_drive), 0);
        smp_in = 12'h0F0; steps(LAT + 1);
        expect_eq("R10 data unaffected", int'(data_out), 12'h0F0);
        expect_eq("R10 valid unaffected", int'(valid_out), 1);
        oe_n = 1'b0; #1;
        expect_eq("R10 drive on", int'(out_drive), 1);

        // random traffic
        tag = "R6";
        for (int i = 0; i < 2000; i++) begin
            smp_in   = W'($urandom);
            ovr_in   = ($urandom % 6) == 0;
            if (($urandom % 40) == 0) fmt_twos = ~fmt_twos;
            oe_n     = ($urandom % 10) == 0;
            std_pd   = ($urandom % 50) == 0;
            quasi_pd = ($urandom % 60) == 0;
            step();
        end
        std_pd = 1'b0; quasi_pd = 1'b0;
        steps(LAT + 2);
        finish_run();
    end

endmodule